// File: doc/BRIEF.md
# Pseudo-Mersenne Residue Channel Reducer

This block reduces one wide signed value, such as a channel product or a sum of several products, modulo a single residue-channel modulus. Each modulus lies close to a power of two: b = 2^W + OFFSET, where OFFSET is a small signed constant. Some moduli sit just below 2^W and others just above it. Because 2^W is congruent to −OFFSET modulo b, the upper part of the operand can be folded back onto the lower part. Each fold needs only a shift, a multiply by a small constant and an add, so no divider is used.

A channel index parameter picks one of eight built-in offsets. Operands enter through a valid/ready handshake at a rate of one per cycle. They pass through three register stages: a first fold, a second fold, and a final correction. The first fold shrinks a 72-bit operand to about 46 bits. The second fold brings it into a window a little wider than the modulus. The correction then makes at most one add or subtract of b, which yields the canonical residue. When the output is not taken, the whole pipeline stalls as one unit.

The pipeline runs in two phases, named here. In RUN, the pipeline advances on every edge. HOLD applies when out_valid is high and out_ready is low: nothing moves, and in_ready is low. The pipeline goes from RUN to HOLD when a valid result meets a low out_ready. It goes back from HOLD to RUN when out_ready rises.

Top module: `rnsr_reducer`

## Requirements
- R1: Whenever out_valid is high, out_residue is strictly less than the modulus b.
- R2: For a non-negative in_data, the result equals in_data mod b.
- R3: in_data is read as a two's-complement signed value. A negative operand yields the non-negative residue r in [0, b) with r ≡ in_data (mod b).
- R4: The parameter CH_IDX picks the modulus offset from 2^33 as follows: index 0 → −1, 1 → −9, 2 → +3, 3 → +11, 4 → +5, 5 → +9, 6 → −31, 7 → +15. This includes moduli above 2^33, whose residues need all 34 output bits.
- R5: Suppose an operand is accepted at clock edge k and out_ready is high at edges k+1 and k+2. Then its result is presented with out_valid high directly after edge k+2, so it is consumed at edge k+3.
- R6: While out_valid is high and out_ready is low, in_ready is low and out_residue holds its value. Results leave in acceptance order, with none lost and none duplicated.
- R7: After reset, out_valid is low and in_ready is high.
- R8: While out_ready is high, in_ready is high, so one operand can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand taken at the edge when both in_valid and in_ready are high |
| in_data | input | IN_W (72) | Signed two's-complement operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_residue | output | W+1 (34) | Canonical residue in [0, b) |

## Verification
The assertions assume that in_valid and out_ready hold known values at every edge after reset. They also assume the operand fits in IN_W signed bits, so the two folds cannot overflow their intermediate widths. The stimulus drives every input on the falling edge, so these conditions always hold. It covers full-scale values of both signs, values next to b and to multiples of 2^33, and random patterns in valid and ready. Two instances are driven with the same stimulus. One uses a modulus below 2^33 and the other a modulus above it, and each is compared against an exact wide-integer remainder.

// File: rtl/rnsr_pkg.sv
package rnsr_pkg;

    localparam int WORD_W = 33;
    localparam int NUM_CH = 8;

    // Signed offset of each channel modulus from 2^WORD_W
    function automatic int chan_offset(input int idx);
        case (idx)
            0:       return -1;
            1:       return -9;
            2:       return 3;
            3:       return 11;
            4:       return 5;
            5:       return 9;
            6:       return -31;
            7:       return 15;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/rnsr_fold.sv
// One folding step: x = hi*2^W + lo  ->  y = lo + hi*ALPHA, where 2^W == ALPHA (mod b)
module rnsr_fold #(
    parameter int IW    = 72,
    parameter int OW    = 46,
    parameter int W     = 33,
    parameter int ALPHA = 1
) (
    input  logic signed [IW-1:0] x,
    output logic signed [OW-1:0] y
);
    localparam int HW = IW - W;

    logic signed [HW-1:0] hi;
    logic signed [OW-1:0] hi_ext;
    logic signed [OW-1:0] lo_ext;

    assign hi     = x[IW-1:W];
    assign hi_ext = OW'(hi);
    assign lo_ext = OW'({1'b0, x[W-1:0]});

    generate
        if (ALPHA == 1) begin : g_add
            assign y = lo_ext + hi_ext;
        end else if (ALPHA == -1) begin : g_sub
            assign y = lo_ext - hi_ext;
        end else begin : g_mul
            localparam logic signed [OW-1:0] A_C = OW'(ALPHA);
            assign y = lo_ext + hi_ext * A_C;
        end
    endgenerate

endmodule

// File: rtl/rnsr_fix.sv
// Final correction: input lies in (-b, 2b); one conditional add or subtract
module rnsr_fix #(
    parameter int YW     = 36,
    parameter int W      = 33,
    parameter int OFFSET = -1
) (
    input  logic signed [YW-1:0] y,
    output logic        [W:0]    r
);
    localparam logic signed [YW-1:0] MODV = (YW'(1) <<< W) + YW'(OFFSET);

    always_comb begin
        if (y < 0) begin
            r = (W+1)'(y + MODV);
        end else if (y >= MODV) begin
            r = (W+1)'(y - MODV);
        end else begin
            r = (W+1)'(y);
        end
    end

endmodule

// File: rtl/rnsr_reducer.sv
module rnsr_reducer #(
    parameter int CH_IDX = 0,
    parameter int IN_W   = 72,
    parameter int W      = rnsr_pkg::WORD_W,
    parameter int A_W    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [IN_W-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W:0]    out_residue
);
    localparam int OFFSET = rnsr_pkg::chan_offset(CH_IDX);
    localparam int ALPHA  = -OFFSET;
    localparam int Y1_W   = IN_W - W + A_W + 1;
    localparam int Y2_W   = W + 3;

    logic                   adv;
    logic                   v1, v2, v3;
    logic signed [Y1_W-1:0] y1_d, y1_q;
    logic signed [Y2_W-1:0] y2_d, y2_q;
    logic        [W:0]      r_d, r_q;

    // RUN when adv is high, HOLD otherwise
    assign adv      = !v3 || out_ready;
    assign in_ready = adv;

    rnsr_fold #(.IW(IN_W), .OW(Y1_W), .W(W), .ALPHA(ALPHA)) u_fold_a (
        .x (in_data),
        .y (y1_d)
    );

    rnsr_fold #(.IW(Y1_W), .OW(Y2_W), .W(W), .ALPHA(ALPHA)) u_fold_b (
        .x (y1_q),
        .y (y2_d)
    );

    rnsr_fix #(.YW(Y2_W), .W(W), .OFFSET(OFFSET)) u_fix (
        .y (y2_q),
        .r (r_d)
    );

    // State register process: the pipeline stages
    always_ff @(posedge clk) begin
        if (rst) begin
            v1   <= 1'b0;
            v2   <= 1'b0;
            v3   <= 1'b0;
            y1_q <= '0;
            y2_q <= '0;
            r_q  <= '0;
        end else if (adv) begin
            v1   <= in_valid;
            v2   <= v1;
            v3   <= v2;
            y1_q <= y1_d;
            y2_q <= y2_d;
            r_q  <= r_d;
        end
    end

    // Output process
    always_comb begin
        out_valid   = v3;
        out_residue = r_q;
    end

endmodule

// File: rtl/rnsr_reducer_chk.sv
module rnsr_reducer_chk #(
    parameter int CH_IDX = 0,
    parameter int W      = rnsr_pkg::WORD_W
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [W:0] out_residue
);
    localparam longint MODL = (longint'(1) << W) + longint'(rnsr_pkg::chan_offset(CH_IDX));

    int cyc;
    always_ff @(posedge clk) begin
        if (rst) cyc <= 0;
        else if (cyc < 3) cyc <= cyc + 1;
    end

    AST_RESIDUE_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'(out_residue) < MODL)); // R1

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3 && $past(in_valid && in_ready, 3) && $past(out_ready, 1) && $past(out_ready, 2))
        |-> out_valid); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_residue))); // R6

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R6

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cyc == 0) |-> (!out_valid && in_ready)); // R7

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready); // R8

endmodule

bind rnsr_reducer rnsr_reducer_chk #(.CH_IDX(CH_IDX), .W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_residue (out_residue)
);

// File: tb/rnsr_reducer_tb.sv
`timescale 1ns/1ps
module rnsr_reducer_tb;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [71:0] in_data = '0;
    logic        out_ready = 1'b1;
    logic        rdy_a, rdy_b, ov_a, ov_b;
    logic [33:0] res_a, res_b;

    int n_checks = 0;
    int n_err    = 0;
    int iter     = 0;

    always #(HALF) clk = ~clk;

    // offset -31 (below 2^33) and offset +11 (above 2^33)
    rnsr_reducer #(.CH_IDX(6)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_a), .in_data(in_data),
        .out_valid(ov_a), .out_ready(out_ready), .out_residue(res_a));

    rnsr_reducer #(.CH_IDX(3)) u_dut_hi (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_b), .in_data(in_data),
        .out_valid(ov_b), .out_ready(out_ready), .out_residue(res_b));

    function automatic logic signed [127:0] modulus(input int off);
        return (128'sd1 <<< 33) + 128'(off);
    endfunction

    function automatic logic [33:0] ref_mod(input logic signed [71:0] x, input int off);
        logic signed [127:0] xx, m, r;
        xx = 128'(x);
        m  = modulus(off);
        r  = xx % m;
        if (r < 0) r = r + m;
        return r[33:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic [33:0] q_a[$], q_b[$];
    int          q_t[$];
    bit          q_n[$];
    bit          lat_phase = 1'b1;
    bit          stall_prev = 1'b0;
    logic [33:0] held_a, held_b;

    task automatic observe();
        logic [33:0] ea, eb;
        int t;
        bit ng;
        iter++;
        chk(ov_a == ov_b && rdy_a == rdy_b, "R6", "instances in step", {ov_a, rdy_a}, {ov_b, rdy_b});
        if (stall_prev) begin
            chk(ov_a && res_a == held_a, "R6", "held residue a", res_a, held_a);
            chk(ov_b && res_b == held_b, "R6", "held residue b", res_b, held_b);
        end
        if (ov_a && !out_ready) chk(!rdy_a, "R6", "in_ready while stalled", rdy_a, 0);
        if (out_ready) chk(rdy_a, "R8", "in_ready with out_ready high", rdy_a, 1);
        if (ov_a && out_ready) begin
            if (q_a.size() == 0) begin
                chk(1'b0, "R6", "unexpected output", res_a, 0);
            end else begin
                ea = q_a.pop_front(); eb = q_b.pop_front();
                t = q_t.pop_front(); ng = q_n.pop_front();
                chk(res_a == ea, ng ? "R3" : "R2", "residue off -31", res_a, ea);
                chk(res_b == eb, "R4", "residue off +11", res_b, eb);
                chk(128'(res_a) < 128'(modulus(-31)), "R1", "range a", res_a, modulus(-31));
                chk(128'(res_b) < 128'(modulus(11)), "R1", "range b", res_b, modulus(11));
                if (lat_phase) chk(iter - t == 3, "R5", "latency", iter - t, 3);
            end
        end
        if (in_valid && rdy_a) begin
            q_a.push_back(ref_mod(in_data, -31));
            q_b.push_back(ref_mod(in_data, 11));
            q_t.push_back(iter);
            q_n.push_back(in_data[71]);
        end
        stall_prev = ov_a && !out_ready;
        held_a = res_a;
        held_b = res_b;
    endtask

    task automatic step(input logic v, input logic [71:0] d, input logic ordy);
        @(negedge clk);
        in_valid  = v;
        in_data   = d;
        out_ready = ordy;
        #1;
        observe();
    endtask

    function automatic logic [71:0] rnd72();
        return {8'($urandom), $urandom, $urandom};
    endfunction

    initial begin
        logic signed [71:0] corners[16];
        corners[0]  = 72'sd0;
        corners[1]  = 72'sd1;
        corners[2]  = -72'sd1;
        corners[3]  = 72'(modulus(-31)) - 72'sd1;
        corners[4]  = 72'(modulus(-31));
        corners[5]  = 72'(modulus(11)) - 72'sd1;
        corners[6]  = 72'(modulus(11));
        corners[7]  = 72'(modulus(11)) + 72'sd1;
        corners[8]  = 72'sd1 <<< 33;
        corners[9]  = -(72'sd1 <<< 33);
        corners[10] = {1'b0, {71{1'b1}}};
        corners[11] = {1'b1, {71{1'b0}}};
        corners[12] = -72'(modulus(11));
        corners[13] = -72'(modulus(-31)) - 72'sd1;
        corners[14] = 72'(modulus(11)) * 72'(modulus(-31));
        corners[15] = (72'sd1 <<< 46) - 72'sd1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!ov_a && !ov_b, "R7", "out_valid after reset", ov_a, 0);
        chk(rdy_a && rdy_b, "R7", "in_ready after reset", rdy_a, 1);

        // Phase 1: no backpressure, latency and full rate checked
        for (int i = 0; i < 16; i++) step(1'b1, corners[i], 1'b1);
        for (int i = 0; i < 150; i++) step(($urandom % 4) != 0, rnd72(), 1'b1);
        for (int i = 0; i < 80; i++) step(1'b1, 72'(-$signed(72'($urandom % 5000))), 1'b1);
        repeat (5) step(1'b0, '0, 1'b1);

        // Phase 2: random backpressure
        lat_phase = 1'b0;
        for (int i = 0; i < 16; i++) step(1'b1, corners[i], ($urandom % 2) == 0);
        for (int i = 0; i < 400; i++) step(($urandom % 3) != 0, rnd72(), ($urandom % 3) != 0);
        repeat (8) step(1'b0, '0, 1'b1);
        chk(q_a.size() == 0, "R6", "all results delivered", q_a.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(HALF * 2.0 * 200000.0);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule